// File: doc/BRIEF.md
# Phase-Accumulator Square-Wave Oscillator

This block synthesises a square wave whose frequency is a programmable fraction of its clock. Each enabled clock adds a 16-bit step value to a 20-bit phase register. A carry out of the top phase bit flips an internal toggle. The toggle therefore completes one full period every two carries, and the output frequency is f_clk × step / 2^21. With a 16 MHz clock, a step of 82 gives roughly 626 Hz and a step of 111 gives roughly 847 Hz.

Software reaches the block through a byte-wide register port with a single shared address. Reads are combinational and writes are synchronous. The 16-bit step is staged: the high byte waits in a holding register and is committed together with the low byte. The phase is never reset when the step changes, so retuning does not glitch the phase.

Each carry also sets a sticky wrap flag. This happens whatever any interrupt logic elsewhere is doing, and the flag stays set until software clears it. A control byte enables the oscillator, drives the pin, chooses the output polarity and reports the current output level.

Top module: `nco_fixed_duty`

## Requirements
- R1: After reset the control byte, phase, step and wrap flag read 0, and `pin_out`, `pin_oe` and `ovf_flag` are 0.
- R2: On every clock edge where the enable is set and no phase byte is written, the phase becomes (phase + step) mod 2^20.
- R3: Each carry out of phase bit 19 inverts the output level one clock later. Over n enabled cycles that start from phase 0, the pin changes floor(n × step / 2^20) times.
- R4: A carry sets the wrap flag (address 6, bit 0, also on `ovf_flag`). Writing address 6 with bit 0 at 0 clears the flag, and writing it with bit 0 at 1 has no effect. If a carry and a clear fall on the same edge, the set wins.
- R5: A write to address 5 only stages the step high byte, and the step in use does not change. A write to address 4 commits {staged high byte, written byte} as the new step in one edge. Reads of addresses 4 and 5 return the committed step.
- R6: Committing a new step leaves the phase untouched, and accumulation continues from the current phase.
- R7: While the enable is clear, the phase holds, the toggle is reset so that the output sits at its inactive level (equal to the polarity bit), and no wrap flag is set even when phase + step would carry.
- R8: Output level = toggle XOR polarity. `pin_oe` equals the pin-enable bit, and `pin_out` is the output level when pin-enable is set and 0 otherwise.
- R9: Addresses 1, 2 and 3 write and read phase bits 7:0, 15:8 and 19:16. Bits 7:4 written to address 3 are dropped and read as 0. A phase byte write takes precedence over the addition on that edge.
- R10: The control byte at address 0 has enable in bit 7, pin-enable in bit 6, the read-only output level in bit 5 and polarity in bit 4 (1 = inverted). Bits 3:0 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| pin_out | output | 1 | Square-wave pin value |
| pin_oe | output | 1 | Pin output enable |
| ovf_flag | output | 1 | Sticky phase-wrap flag |

## Verification
A phase register that adds the wrong amount, or drops or keeps the wrong bits, shows up as a wrong phase readback right after a run of known length. Over a long run it also shows up as the wrong number of pin transitions, because the transition count is floor(n × step / 2^20). A toggle or wrap flag that misses a carry shows on `pin_out` or `ovf_flag` one clock after the carry edge. A step committed on the high-byte write, or a phase that is cleared on retune, changes the phase readback after a few cycles. A disabled block that still counts shows as a phase that drifts while the enable bit is clear.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int ACC_BITS = 20;
  localparam int INC_BITS = 16;
  localparam int BYTE_W   = 8;
  localparam int LANES    = (ACC_BITS + BYTE_W - 1) / BYTE_W;
  localparam int ADDR_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_ACC0 = 3'd1,
    A_ACC1 = 3'd2,
    A_ACC2 = 3'd3,
    A_INCL = 3'd4,
    A_INCH = 3'd5,
    A_FLAG = 3'd6
  } reg_addr_e;

  // phase plus step, with the carry kept in the top bit
  function automatic logic [ACC_BITS:0] acc_step(input logic [ACC_BITS-1:0] a,
                                                 input logic [INC_BITS-1:0] inc);
    return {1'b0, a} + {{(ACC_BITS + 1 - INC_BITS){1'b0}}, inc};
  endfunction

  // replace one byte lane of the phase; bits beyond the phase width are dropped
  function automatic logic [ACC_BITS-1:0] lane_merge(input logic [ACC_BITS-1:0] a,
                                                     input int lane,
                                                     input logic [BYTE_W-1:0] d);
    logic [ACC_BITS-1:0] r;
    r = a;
    for (int b = 0; b < BYTE_W; b++)
      if (lane * BYTE_W + b < ACC_BITS) r[lane * BYTE_W + b] = d[b];
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] lane_read(input logic [ACC_BITS-1:0] a,
                                                  input int lane);
    logic [BYTE_W-1:0] r;
    r = '0;
    for (int b = 0; b < BYTE_W; b++)
      if (lane * BYTE_W + b < ACC_BITS) r[b] = a[lane * BYTE_W + b];
    return r;
  endfunction
endpackage

// File: rtl/nco_ctrl_regs.sv
module nco_ctrl_regs
  import nco_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic                en,
  output logic                pin_en,
  output logic                pol,
  output logic [INC_BITS-1:0] inc,
  output logic                flag_clr,
  output logic [LANES-1:0]    lane_wr
);
  logic [BYTE_W-1:0] inc_hi_stage;
  logic              inc_lo_wr;
  logic              inc_hi_wr;
  logic              ctrl_wr;

  assign ctrl_wr   = wr_en && (addr == A_CTRL);
  assign inc_lo_wr = wr_en && (addr == A_INCL);
  assign inc_hi_wr = wr_en && (addr == A_INCH);
  assign flag_clr  = wr_en && (addr == A_FLAG) && !wr_data[0];

  for (genvar l = 0; l < LANES; l++) begin : g_lane_dec
    assign lane_wr[l] = wr_en && (addr == ADDR_W'(int'(A_ACC0) + l));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      pin_en <= 1'b0;
      pol    <= 1'b0;
    end else if (ctrl_wr) begin
      en     <= wr_data[7];
      pin_en <= wr_data[6];
      pol    <= wr_data[4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_hi_stage <= '0;
      inc          <= '0;
    end else begin
      if (inc_hi_wr) inc_hi_stage <= wr_data;
      if (inc_lo_wr) inc          <= {inc_hi_stage, wr_data};
    end
  end

  // R5: a low-byte write commits the staged high byte with it
  assert_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inc_lo_wr |=> inc == {$past(inc_hi_stage), $past(wr_data)});
  // R5: a high-byte write alone leaves the step in use unchanged
  assert_staged_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inc_hi_wr |=> $stable(inc));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
  import nco_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [INC_BITS-1:0] inc,
  input  logic [LANES-1:0]    lane_wr,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic [ACC_BITS-1:0] acc,
  output logic                ovf_evt
);
  logic [ACC_BITS:0]   sum;
  logic [ACC_BITS-1:0] acc_d;
  logic                any_lane_wr;
  logic                stepping;

  assign sum         = acc_step(acc, inc);
  assign any_lane_wr = |lane_wr;
  assign stepping    = en && !any_lane_wr;
  assign ovf_evt     = stepping && sum[ACC_BITS];

  always_comb begin
    acc_d = acc;
    for (int l = 0; l < LANES; l++)
      if (lane_wr[l]) acc_d = lane_merge(acc_d, l, wr_data);
    if (stepping) acc_d = sum[ACC_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_d;
  end

  // R7: a disabled oscillator without byte writes keeps its phase
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !any_lane_wr) |=> $stable(acc));
  // R7: no carry events while disabled
  assert_no_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !ovf_evt);
  // R2: without a carry the phase never moves backwards
  assert_monotone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping && !ovf_evt) |=> acc >= $past(acc));
  // R3: a carry leaves a wrapped remainder below the old phase
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> acc < $past(acc));
endmodule

// File: rtl/nco_wave_gen.sv
module nco_wave_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pol,
  input  logic pin_en,
  input  logic ovf_evt,
  input  logic flag_clr,
  output logic level,
  output logic pin_out,
  output logic flag
);
  logic tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tog <= 1'b0;
    else if (!en)     tog <= 1'b0;
    else if (ovf_evt) tog <= ~tog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (ovf_evt)  flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  assign level   = tog ^ pol;
  assign pin_out = pin_en & level;

  // R3: every carry flips the toggle on the next edge
  assert_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ovf_evt) |=> tog != $past(tog));
  // R4: a carry always leaves the wrap flag set, clear request or not
  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flag);
  // R7: a disabled cycle parks the toggle at its inactive state
  assert_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tog);
  // R4: without a carry or clear the flag keeps its value
  assert_flag_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_evt && !flag_clr) |=> $stable(flag));
endmodule

// File: rtl/nco_fixed_duty.sv
module nco_fixed_duty
  import nco_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              ovf_flag
);
  logic                en;
  logic                pin_en;
  logic                pol;
  logic [INC_BITS-1:0] inc;
  logic                flag_clr;
  logic [LANES-1:0]    lane_wr;
  logic [ACC_BITS-1:0] acc;
  logic                ovf_evt;
  logic                level;

  nco_ctrl_regs i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .en       (en),
    .pin_en   (pin_en),
    .pol      (pol),
    .inc      (inc),
    .flag_clr (flag_clr),
    .lane_wr  (lane_wr)
  );

  nco_phase_acc i_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .inc     (inc),
    .lane_wr (lane_wr),
    .wr_data (wr_data),
    .acc     (acc),
    .ovf_evt (ovf_evt)
  );

  nco_wave_gen i_wave (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .pol      (pol),
    .pin_en   (pin_en),
    .ovf_evt  (ovf_evt),
    .flag_clr (flag_clr),
    .level    (level),
    .pin_out  (pin_out),
    .flag     (ovf_flag)
  );

  assign pin_oe = pin_en;

  always_comb begin
    unique case (addr)
      A_CTRL:  rd_data = {en, pin_en, level, pol, 4'b0000};
      A_ACC0:  rd_data = lane_read(acc, 0);
      A_ACC1:  rd_data = lane_read(acc, 1);
      A_ACC2:  rd_data = lane_read(acc, 2);
      A_INCL:  rd_data = inc[BYTE_W-1:0];
      A_INCH:  rd_data = inc[INC_BITS-1:BYTE_W];
      A_FLAG:  rd_data = {7'b0, ovf_flag};
      default: rd_data = '0;
    endcase
  end

  // R8: the pin follows the output level while driven and is low otherwise
  assert_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out == (pin_oe && rd_data_level()));
  // R10: the reserved control bits never read as 1
  assert_ctrl_rsvd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CTRL) |-> rd_data[3:0] == 4'b0000);

  function automatic logic rd_data_level();
    return level;
  endfunction
endmodule

// File: tb/test_nco_fixed_duty.sv
`timescale 1ns/1ps
module test_nco_fixed_duty;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       pin_out;
  logic       pin_oe;
  logic       ovf_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int toggles;

  always #5 clk = ~clk;

  nco_fixed_duty i_nco_fixed_duty (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe), .ovf_flag(ovf_flag)
  );

  localparam int NV = 6;
  localparam logic [15:0] VEC_INC [NV] = '{16'd82, 16'd111, 16'hFFFF, 16'd1, 16'h8000, 16'd0};
  localparam int          VEC_N   [NV] = '{20000, 20000, 40, 5, 100, 50};

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // entered at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic rd_acc(output longint v);
    logic [7:0] b0, b1, b2;
    rd(3'd1, b0); rd(3'd2, b1); rd(3'd3, b2);
    v = {b2, b1, b0};
  endtask

  task automatic set_acc(input logic [19:0] v);
    wr(3'd1, v[7:0]); wr(3'd2, v[15:8]); wr(3'd3, {4'd0, v[19:16]});
  endtask

  task automatic set_inc(input logic [15:0] v);
    wr(3'd5, v[15:8]); wr(3'd4, v[7:0]);
  endtask

  // n enabled cycles with pin driven; counts pin transitions
  task automatic run(input int n);
    logic prev;
    toggles = 0;
    prev = pin_out;
    wr(3'd0, 8'hC0);
    for (int i = 0; i < n - 1; i++) begin
      if (pin_out != prev) toggles++;
      prev = pin_out;
      @(negedge clk);
    end
    if (pin_out != prev) toggles++;
    prev = pin_out;
    wr(3'd0, 8'h40);
    if (pin_out != prev) toggles++;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    longint v, prod;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, b); chk("R1 ctrl", b, 0);
    rd_acc(v);   chk("R1 phase", v, 0);
    rd(3'd4, b); chk("R1 step lo", b, 0);
    rd(3'd6, b); chk("R1 flag", b, 0);
    chk("R1 pins", {pin_out, pin_oe, ovf_flag}, 0);

    // vector walk: R2 phase, R3 transitions, R4 flag
    for (int k = 0; k < NV; k++) begin
      wr(3'd6, 8'h00);
      set_acc(20'd0);
      set_inc(VEC_INC[k]);
      run(VEC_N[k]);
      prod = longint'(VEC_N[k]) * longint'(VEC_INC[k]);
      rd_acc(v);
      chk("R2 phase after run", v, prod % (64'd1 << 20));
      chk("R3 pin transitions", toggles, prod >> 20);
      chk("R4 flag after run", ovf_flag, (prod >> 20) > 0);
    end

    // R9/R3 wrap remainder from a byte-written phase
    wr(3'd6, 8'h00);
    set_acc(20'hFFFFE);
    set_inc(16'd3);
    run(1);
    rd_acc(v);
    chk("R9 wrapped remainder", v, 1);
    chk("R3 one transition", toggles, 1);
    // R4 writing bit0=1 does not clear, bit0=0 clears
    wr(3'd6, 8'h01);
    chk("R4 write one keeps flag", ovf_flag, 1);
    wr(3'd6, 8'hFE);
    chk("R4 write zero clears", ovf_flag, 0);

    // R5 staging and R6 phase continuity
    set_acc(20'd0);
    set_inc(16'd5);
    wr(3'd5, 8'h01);
    rd(3'd5, b); chk("R5 staged byte not applied", b, 0);
    run(4);
    rd_acc(v); chk("R5 old step still used", v, 20);
    wr(3'd4, 8'h00);
    rd(3'd5, b); chk("R5 high byte committed", b, 1);
    run(2);
    rd_acc(v); chk("R6 phase continues after retune", v, 532);

    // R7 hold while disabled
    repeat (10) @(negedge clk);
    rd_acc(v); chk("R7 phase holds", v, 532);
    chk("R7 pin inactive", pin_out, 0);
    set_acc(20'hFFFFF);
    set_inc(16'h0100);
    repeat (20) @(negedge clk);
    chk("R7 no flag while disabled", ovf_flag, 0);
    rd_acc(v); chk("R7 phase frozen near carry", v, 20'hFFFFF);

    // R9 upper lane truncation and write precedence over the add
    wr(3'd3, 8'hFF);
    rd(3'd3, b); chk("R9 upper lane bits", b, 8'h0F);
    wr(3'd6, 8'h00);
    set_acc(20'd0);
    set_inc(16'd7);
    wr(3'd0, 8'h80);
    wr(3'd1, 8'h40);
    wr(3'd0, 8'h00);
    rd_acc(v); chk("R9 write wins over add", v, 8'h40 + 7);

    // R8/R10 polarity, pin enable, control layout
    wr(3'd0, 8'h5F);
    rd(3'd0, b); chk("R10 ctrl readback", b, 8'h70);
    chk("R8 inverted inactive pin", pin_out, 1);
    chk("R8 pin oe", pin_oe, 1);
    wr(3'd0, 8'h1F);
    rd(3'd0, b); chk("R10 ctrl no pin", b, 8'h30);
    chk("R8 pin gated low", {pin_out, pin_oe}, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule